// File: doc/BRIEF.md
# Sample-Delay Tap Sweep and Window Centring

This block tunes the sampling delay of a card interface receive path. On `start` it takes an initial 32-bit delay word and a path selection (command line or data read path). It then steps an 8-bit tap value through every setting from 0 to 255 in ascending order. For each setting it places the tap into the field of the delay word that belongs to the selected path, presents the resulting word on `dly_word`, and asks an external responder for one pass/fail probe.

While the sweep runs, the block tracks the runs of consecutive passing taps. When the last tap has been judged, it takes the longest run and selects the tap in its centre. It then writes the initial word, with that tap in the selected field, back to `dly_word`. If no tap passed, it raises `err` and restores the initial word unchanged. A companion configuration word is also taken at start and driven out with its compensation-enable field cleared, so the delay line holds still during the sweep.

The probe interface is a request/result handshake. `probe_req` is the request, and `res_valid` qualifies `res_pass`. A result is accepted only on a clock edge where both `probe_req` and `res_valid` are high. The responder may hold back a result for as many cycles as it needs. During that time `probe_req` and `dly_word` stay frozen, and the block never times out.

Top module: `tune_sweep`

## Requirements
- R1: While reset is asserted, and after it is released, `dly_word`, `cfg_word`, `probe_req`, `busy`, `done` and `err` are all 0.
- R2: A `start` seen while idle latches `init_word`, `path_sel` and `cfg_in`. One edge later, `cfg_word` equals `cfg_in` with bits [27:24] forced to 0 and every other bit kept, `busy` and `probe_req` are 1, and `dly_word` carries tap 0.
- R3: The tap field depends on `path_sel`. When `path_sel`=0 (command line) the tap is in `dly_word[15:8]`. When `path_sel`=1 (data read path) it is in `dly_word[23:16]`. All other bits equal the latched `init_word` for the whole sweep and in the final word.
- R4: The tap starts at 0 and rises by one after each accepted result, up to 255: exactly 256 probes. While `probe_req` is high and `res_valid` is low, `probe_req` and `dly_word` stay unchanged.
- R5: The final tap is E − (L − 1)/2, using integer division. L is the length of the longest run of consecutive passing taps, and E is the last tap of that run.
- R6: Between runs of equal length, the earliest one wins.
- R7: A passing run that ends at tap 255 competes like any other run.
- R8: If no tap passes, `err` is 1 with `done`, and the final `dly_word` equals the latched `init_word` bit for bit.
- R9: `probe_req` falls on the edge that accepts the 256th result. On the next edge `done` pulses for exactly one cycle, `busy` falls, and the final `dly_word` and `err` appear. Both then hold until the next start, which clears `err`.
- R10: `start` is ignored while a sweep is running. `res_valid` is ignored while `probe_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sweep (taken only while idle) |
| path_sel | input | 1 | 0 = command line field [15:8], 1 = data read field [23:16] |
| init_word | input | 32 | Initial delay word, latched at start |
| cfg_in | input | 32 | Delay-line configuration word, latched at start |
| probe_req | output | 1 | Request for a pass/fail probe at the current tap |
| res_valid | input | 1 | Probe result is present |
| res_pass | input | 1 | Probe result: 1 = pass |
| dly_word | output | 32 | Delay word: sweep tap during the run, tuned value after |
| cfg_word | output | 32 | Latched configuration with compensation enables [27:24] cleared |
| busy | output | 1 | Sweep or final selection in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | No passing tap in the last sweep |

## Verification
Each result has a fixed delay after its stimulus. `cfg_word`, `probe_req` and the tap-0 word are due one edge after `start`. Each new tap is due one edge after the edge that accepts a result, and `probe_req` is already low after the edge that takes the 256th result. `done`, `err` and the final word arrive one edge later still. The bench drives every input at a falling edge and samples at the next falling edge after the rising edge that should produce the change. It checks the tap field and the preserved bits at every request, including during deliberate stalls of the responder. A reference model runs the longest-run search on the same pass pattern to give the expected final tap.

// File: rtl/tune_pkg.sv
package tune_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PROBE  = 2'd1,
    ST_FINISH = 2'd2
  } tune_state_e;

  typedef enum logic {
    PATH_CMD  = 1'b0,
    PATH_DATA = 1'b1
  } tune_path_e;

endpackage

// File: rtl/tune_field_insert.sv
module tune_field_insert #(
  parameter int WORD_W   = 32,
  parameter int TAP_W    = 8,
  parameter int CMD_LSB  = 8,
  parameter int DATA_LSB = 16
) (
  input  logic [WORD_W-1:0] base,
  input  logic              path,
  input  logic [TAP_W-1:0]  tap,
  output logic [WORD_W-1:0] word
);
  import tune_pkg::*;

  always_comb begin
    word = base;
    if (tune_path_e'(path) == PATH_DATA) word[DATA_LSB +: TAP_W] = tap;
    else                                 word[CMD_LSB  +: TAP_W] = tap;
  end

endmodule

// File: rtl/tune_run_track.sv
module tune_run_track #(
  parameter int TAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             upd,
  input  logic             pass,
  input  logic [TAP_W-1:0] tap,
  output logic [TAP_W:0]   run_len,
  output logic [TAP_W:0]   best_len,
  output logic [TAP_W-1:0] best_end
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len  <= '0;
      best_len <= '0;
      best_end <= '0;
    end else if (clr) begin
      run_len  <= '0;
      best_len <= '0;
      best_end <= '0;
    end else if (upd) begin
      if (pass) begin
        run_len <= run_len + 1'b1;
      end else begin
        if (run_len > best_len) begin
          best_len <= run_len;
          best_end <= tap - 1'b1;
        end
        run_len <= '0;
      end
    end
  end

endmodule

// File: rtl/tune_pick.sv
module tune_pick #(
  parameter int TAP_W = 8
) (
  input  logic [TAP_W:0]   run_len,
  input  logic [TAP_W:0]   best_len,
  input  logic [TAP_W-1:0] best_end,
  output logic             found,
  output logic [TAP_W-1:0] pick
);
  localparam int LEN_W = TAP_W + 1;

  logic [LEN_W-1:0] fin_len;
  logic [TAP_W-1:0] fin_end;
  logic [LEN_W-1:0] half;

  always_comb begin
    if (run_len > best_len) begin
      fin_len = run_len;
      fin_end = '1;
    end else begin
      fin_len = best_len;
      fin_end = best_end;
    end
    found = (fin_len != '0);
    half  = (fin_len - LEN_W'(1)) >> 1;
    pick  = fin_end - half[TAP_W-1:0];
  end

endmodule

// File: rtl/tune_sweep.sv
module tune_sweep #(
  parameter int WORD_W   = 32,
  parameter int TAP_W    = 8,
  parameter int CMD_LSB  = 8,
  parameter int DATA_LSB = 16,
  parameter int CPST_LSB = 24,
  parameter int CPST_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              path_sel,
  input  logic [WORD_W-1:0] init_word,
  input  logic [WORD_W-1:0] cfg_in,
  output logic              probe_req,
  input  logic              res_valid,
  input  logic              res_pass,
  output logic [WORD_W-1:0] dly_word,
  output logic [WORD_W-1:0] cfg_word,
  output logic              busy,
  output logic              done,
  output logic              err
);
  import tune_pkg::*;

  localparam int LEN_W = TAP_W + 1;
  localparam logic [WORD_W-1:0] CPST_MASK =
    WORD_W'(((64'd1 << CPST_W) - 64'd1) << CPST_LSB);

  tune_state_e       state_q;
  logic [TAP_W-1:0]  tap_q;
  logic              path_q;
  logic [WORD_W-1:0] base_q;
  logic [WORD_W-1:0] dly_q;
  logic [WORD_W-1:0] cfg_q;
  logic              req_q;
  logic              done_q;
  logic              err_q;

  logic              accept;
  logic              last_tap;
  logic              trk_clr;
  logic [LEN_W-1:0]  run_len;
  logic [LEN_W-1:0]  best_len;
  logic [TAP_W-1:0]  best_end;
  logic              found;
  logic [TAP_W-1:0]  pick;

  logic [WORD_W-1:0] ins_base;
  logic              ins_path;
  logic [TAP_W-1:0]  ins_tap;
  logic [WORD_W-1:0] ins_word;

  assign accept   = (state_q == ST_PROBE) && req_q && res_valid;
  assign last_tap = (tap_q == '1);
  assign trk_clr  = (state_q == ST_IDLE) && start;

  always_comb begin
    unique case (state_q)
      ST_IDLE: begin
        ins_base = init_word;
        ins_path = path_sel;
        ins_tap  = '0;
      end
      ST_FINISH: begin
        ins_base = base_q;
        ins_path = path_q;
        ins_tap  = pick;
      end
      default: begin
        ins_base = base_q;
        ins_path = path_q;
        ins_tap  = tap_q + 1'b1;
      end
    endcase
  end

  tune_field_insert #(
    .WORD_W  (WORD_W),
    .TAP_W   (TAP_W),
    .CMD_LSB (CMD_LSB),
    .DATA_LSB(DATA_LSB)
  ) u_insert (
    .base(ins_base),
    .path(ins_path),
    .tap (ins_tap),
    .word(ins_word)
  );

  tune_run_track #(.TAP_W(TAP_W)) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (trk_clr),
    .upd     (accept),
    .pass    (res_pass),
    .tap     (tap_q),
    .run_len (run_len),
    .best_len(best_len),
    .best_end(best_end)
  );

  tune_pick #(.TAP_W(TAP_W)) u_pick (
    .run_len (run_len),
    .best_len(best_len),
    .best_end(best_end),
    .found   (found),
    .pick    (pick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tap_q   <= '0;
      path_q  <= 1'b0;
      base_q  <= '0;
      dly_q   <= '0;
      cfg_q   <= '0;
      req_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            path_q  <= path_sel;
            base_q  <= init_word;
            cfg_q   <= cfg_in & ~CPST_MASK;
            tap_q   <= '0;
            dly_q   <= ins_word;
            req_q   <= 1'b1;
            err_q   <= 1'b0;
            state_q <= ST_PROBE;
          end
        end
        ST_PROBE: begin
          if (accept) begin
            if (last_tap) begin
              req_q   <= 1'b0;
              state_q <= ST_FINISH;
            end else begin
              tap_q <= tap_q + 1'b1;
              dly_q <= ins_word;
            end
          end
        end
        ST_FINISH: begin
          dly_q   <= found ? ins_word : base_q;
          err_q   <= ~found;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign probe_req = req_q;
  assign dly_word  = dly_q;
  assign cfg_word  = cfg_q;
  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign err       = err_q;

endmodule

// File: rtl/tune_sweep_chk.sv
module tune_sweep_chk #(
  parameter int WORD_W   = 32,
  parameter int TAP_W    = 8,
  parameter int CMD_LSB  = 8,
  parameter int DATA_LSB = 16,
  parameter int CPST_LSB = 24,
  parameter int CPST_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              probe_req,
  input logic              res_valid,
  input logic [WORD_W-1:0] dly_word,
  input logic [WORD_W-1:0] cfg_word,
  input logic              busy,
  input logic              done
);
  localparam logic [WORD_W-1:0] TAP_ONES = WORD_W'((64'd1 << TAP_W) - 64'd1);
  localparam logic [WORD_W-1:0] KEEP =
    ~((TAP_ONES << CMD_LSB) | (TAP_ONES << DATA_LSB));

  assert_hold_while_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_req && !res_valid) |=> (probe_req && $stable(dly_word)));

  assert_req_only_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    probe_req |-> busy);

  assert_keep_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_req && $past(probe_req)) |-> ((dly_word & KEEP) == ($past(dly_word) & KEEP)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!probe_req && !busy));

  assert_cpst_cleared_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cfg_word[CPST_LSB +: CPST_W] == '0));

endmodule

bind tune_sweep tune_sweep_chk #(
  .WORD_W  (WORD_W),
  .TAP_W   (TAP_W),
  .CMD_LSB (CMD_LSB),
  .DATA_LSB(DATA_LSB),
  .CPST_LSB(CPST_LSB),
  .CPST_W  (CPST_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .probe_req(probe_req),
  .res_valid(res_valid),
  .dly_word (dly_word),
  .cfg_word (cfg_word),
  .busy     (busy),
  .done     (done)
);

// File: tb/tune_sweep_test.sv
module tune_sweep_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        path_sel = 1'b0;
  logic [31:0] init_word = '0;
  logic [31:0] cfg_in = '0;
  logic        probe_req;
  logic        res_valid = 1'b0;
  logic        res_pass = 1'b0;
  logic [31:0] dly_word;
  logic [31:0] cfg_word;
  logic        busy;
  logic        done;
  logic        err;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  tune_sweep uut (
    .clk(clk), .rst_n(rst_n), .start(start), .path_sel(path_sel),
    .init_word(init_word), .cfg_in(cfg_in), .probe_req(probe_req),
    .res_valid(res_valid), .res_pass(res_pass), .dly_word(dly_word),
    .cfg_word(cfg_word), .busy(busy), .done(done), .err(err)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic bit pat(int id, int t);
    case (id)
      0: return (t >= 40 && t <= 99) || (t >= 150 && t <= 160);
      1: return (t >= 10 && t <= 19) || (t >= 30 && t <= 39);
      2: return (t >= 5 && t <= 9) || (t >= 200);
      3: return 1'b0;
      4: return 1'b1;
      default: return (t == 0);
    endcase
  endfunction

  function automatic int ref_pick(int id, output bit ok);
    int run = 0, blen = 0, bend = 0;
    for (int t = 0; t < 256; t++) begin
      if (pat(id, t)) run++;
      else begin
        if (run > blen) begin blen = run; bend = t - 1; end
        run = 0;
      end
    end
    if (run > blen) begin blen = run; bend = 255; end
    ok = (blen > 0);
    return ok ? bend - (blen - 1) / 2 : 0;
  endfunction

  function automatic logic [31:0] put_tap(logic [31:0] w, bit md, int tap);
    logic [31:0] r = w;
    if (md) r[23:16] = 8'(tap);
    else    r[15:8]  = 8'(tap);
    return r;
  endfunction

  function automatic logic [7:0] get_tap(logic [31:0] w, bit md);
    return md ? w[23:16] : w[15:8];
  endfunction

  // One complete sweep; stall adds responder gaps, poke raises start mid-run.
  task automatic run_sweep(int id, bit md, logic [31:0] init, logic [31:0] cfg,
                           bit stall, bit poke, string tag);
    bit          seq_ok = 1'b1;
    bit          ok;
    int          exp_tap;
    logic [31:0] exp_word;
    logic [31:0] held;
    @(negedge clk);
    start = 1'b1; path_sel = md; init_word = init; cfg_in = cfg;
    @(negedge clk);
    start = 1'b0; init_word = ~init; path_sel = ~md; cfg_in = '1;
    chk({tag, " R2 cfg_word"}, cfg_word, cfg & 32'hF0FF_FFFF);
    chk({tag, " R2 probe_req"}, {31'd0, probe_req}, 32'd1);
    chk({tag, " R2 busy"}, {31'd0, busy}, 32'd1);
    for (int t = 0; t < 256; t++) begin
      if (probe_req !== 1'b1 || get_tap(dly_word, md) !== 8'(t) ||
          dly_word !== put_tap(init, md, t)) seq_ok = 1'b0;
      if (stall) begin
        held = dly_word;
        for (int g = 0; g < (t % 3); g++) begin
          @(negedge clk);
          if (probe_req !== 1'b1 || dly_word !== held) seq_ok = 1'b0;
        end
      end
      if (poke && t == 50) start = 1'b1;
      res_valid = 1'b1;
      res_pass  = pat(id, t);
      @(negedge clk);
      res_valid = 1'b0;
      start     = 1'b0;
    end
    chk({tag, " R3/R4 tap sequence and kept bits"}, {31'd0, seq_ok}, 32'd1);
    chk({tag, " R9 probe_req low after last"}, {31'd0, probe_req}, 32'd0);
    chk({tag, " R9 done not early"}, {31'd0, done}, 32'd0);
    @(negedge clk);
    exp_tap  = ref_pick(id, ok);
    exp_word = ok ? put_tap(init, md, exp_tap) : init;
    chk({tag, " R9 done pulse"}, {31'd0, done}, 32'd1);
    chk({tag, " R9 busy low"}, {31'd0, busy}, 32'd0);
    chk({tag, " R5 final word"}, dly_word, exp_word);
    chk({tag, " R8 err"}, {31'd0, err}, {31'd0, ~ok});
    @(negedge clk);
    chk({tag, " R9 done one cycle"}, {31'd0, done}, 32'd0);
    chk({tag, " R9 word held"}, dly_word, exp_word);
    chk({tag, " R9 err held"}, {31'd0, err}, {31'd0, ~ok});
  endtask

  task automatic test_reset();
    repeat (2) @(negedge clk);
    chk("R1 dly_word in reset", dly_word, 32'd0);
    chk("R1 flags in reset", {26'd0, probe_req, busy, done, err, 2'b00}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 dly_word after reset", dly_word, 32'd0);
    chk("R1 cfg_word after reset", cfg_word, 32'd0);
    chk("R1 flags after reset", {28'd0, probe_req, busy, done, err}, 32'd0);
  endtask

  task automatic test_idle_result();
    res_valid = 1'b1; res_pass = 1'b1;
    @(negedge clk);
    res_valid = 1'b0;
    @(negedge clk);
    chk("R10 stray result: dly_word", dly_word, 32'd0);
    chk("R10 stray result: flags", {28'd0, probe_req, busy, done, err}, 32'd0);
  endtask

  initial begin
    test_reset();
    test_idle_result();
    run_sweep(0, 1'b0, 32'hA5C3_7E19, 32'h1234_5678, 1'b1, 1'b1, "cmd/R10 start ignored");
    run_sweep(1, 1'b1, 32'h0F0F_F0F0, 32'hFFFF_FFFF, 1'b0, 1'b0, "data R6 tie");
    run_sweep(2, 1'b0, 32'hDEAD_BEEF, 32'h0A00_0001, 1'b1, 1'b0, "R7 end run");
    run_sweep(3, 1'b1, 32'h8765_4321, 32'h0F00_0000, 1'b0, 1'b0, "R8 all fail");
    run_sweep(4, 1'b1, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0, "all pass");
    run_sweep(5, 1'b0, 32'hFFFF_FFFF, 32'h5555_AAAA, 1'b0, 1'b0, "single tap 0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R4 watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule